// File: doc/BRIEF.md
# Mapped Interrupt Controller Core

This block gathers a group of system interrupt request lines and turns them into a small number of host interrupt outputs. Each request line is conditioned on its own terms: it can be treated as a level request or as an edge request, and its polarity decides which level or which edge counts as active. A conditioned request sets a sticky pending bit. Software clears a pending bit by writing 1 to it.

Every source has its own enable. Software changes an enable by writing the source number to a set-index or clear-index register. The pending bits of enabled sources are routed in two stages. A byte-wide field per source names a channel, and a byte-wide field per channel names a host output. Fields are packed four to a 32-bit word. Each host output has its own enable, and one global enable bit gates every host output.

The register port is a plain synchronous 32-bit bus with a word address. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `mapintc_core`

Register map (word addresses):

| Address | Register |
|---|---|
| 0x00 | revision (read-only) |
| 0x01 | global enable |
| 0x02 | pending |
| 0x03 | enable readback |
| 0x04 | enable set index |
| 0x05 | enable clear index |
| 0x06 | host enable mask |
| 0x07 | host set index |
| 0x08 | host clear index |
| 0x09 | type |
| 0x0A | polarity |
| 0x10+ | source maps |
| 0x18+ | channel maps |

## Requirements
- R1: Address 0x00 always reads the constant 0x00010203. After reset all pending bits, source enables, host enables, the global enable and all map fields are 0, type bits are 0 (level) and polarity bits are 1 (active high), and every host output is low.
- R2: A source whose type bit is 0 sets its pending bit at each clock edge where its input equals its polarity bit. If the input is still active when a clear is written, the bit stays set, because a set takes priority over a clear in the same cycle.
- R3: A source whose type bit is 1 sets its pending bit only at an edge where its input has changed since the previous clock edge to the value of its polarity bit (1 = rising, 0 = falling). The bit then stays set after the input returns.
- R4: Writing to the pending register (0x02) clears each bit written as 1. Bits written as 0 keep their value. With no such write, a pending bit never falls.
- R5: Writing value n to 0x04 sets the enable of source n only. Writing n to 0x05 clears it only. A value not below the source count changes nothing. Address 0x03 reads the enables as a bitmask.
- R6: Address 0x06 reads and writes the host enable bitmask, where 0x3 enables hosts 0 and 1. Writing n to 0x07 sets host enable n only, and writing n to 0x08 clears it only. A host output is never high while its enable is 0.
- R7: The channel of source s is the byte at bits 8k+7:8k, with k = s mod 4, of the word at address 0x10 + s/4. A channel value not below the channel count routes the source nowhere.
- R8: The host of channel c is the byte at bits 8k+7:8k, with k = c mod 4, of the word at address 0x18 + c/4. A host value not below the host count routes the channel nowhere.
- R9: Bit 0 of address 0x01 is the global enable. While it is 0, every host output is low.
- R10: Host output h is high in the same cycle the registered state allows it. That is when the global enable is 1, host enable h is 1, and some source is both pending and enabled and maps through its channel to host h.
- R11: Clearing a source's enable does not clear its pending bit. Enabling it again raises the output again with no new input activity.
- R12: Addresses 0x09 and 0x0A hold the type and polarity bits of source s at bit s. Addresses with no register, and the four index registers, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for bus_addr, combinational |
| src_in | input | NSRC | Interrupt request inputs, synchronous to clk |
| host_irq | output | NHOST | Host interrupt outputs, active high |

## Verification
Directed steps hold a level source active across a clear, which separates set-over-clear priority from a plain clear. An edge source with falling polarity is held high and then lowered, which shows whether edge detection follows the polarity bit. Routing is tried with a source moved to a non-zero channel, that channel sent to host 1, and then with out-of-range channel and host values, which shows whether both map stages and their range guards work. A long stretch of seeded random input toggling and register writes, with random index values that include out-of-range ones, is then compared every cycle against a bench model of the host outputs and one register readback. This exposes errors in ordering within a cycle, such as status computed from freshly written type bits.

// File: rtl/mapintc_pkg.sv
package mapintc_pkg;
   localparam int A_REV   = 'h00;
   localparam int A_GLB   = 'h01;
   localparam int A_STAT  = 'h02;
   localparam int A_EN    = 'h03;
   localparam int A_ESET  = 'h04;
   localparam int A_ECLR  = 'h05;
   localparam int A_HEN   = 'h06;
   localparam int A_HSET  = 'h07;
   localparam int A_HCLR  = 'h08;
   localparam int A_TYPE  = 'h09;
   localparam int A_POL   = 'h0A;
   localparam int A_SMAP  = 'h10;
   localparam int A_HMAP  = 'h18;
   localparam logic [31:0] REV_ID = 32'h0001_0203;
endpackage

// File: rtl/mapintc_srccond.sv
module mapintc_srccond #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_in,
   input  logic [NSRC-1:0] typ,
   input  logic [NSRC-1:0] pol,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] stat
);
   for (genvar g = 0; g < NSRC; g++) begin : g_src
      logic prev_q;
      logic stat_q;
      logic active;
      logic trig;

      assign active = (src_in[g] == pol[g]);

      always_comb begin
         if (typ[g]) trig = active && (src_in[g] != prev_q);
         else        trig = active;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q <= 1'b0;
            stat_q <= 1'b0;
         end else begin
            prev_q <= src_in[g];
            stat_q <= trig | (stat_q & ~clr[g]);
         end
      end

      assign stat[g] = stat_q;
   end
endmodule

// File: rtl/mapintc_route.sv
module mapintc_route #(
   parameter int NSRC  = 32,
   parameter int NCHAN = 8,
   parameter int NHOST = 2
) (
   input  logic [NSRC-1:0]       live,
   input  logic [NSRC-1:0][7:0]  smap,
   input  logic [NCHAN-1:0][7:0] hmap,
   input  logic [NHOST-1:0]      hen,
   input  logic                  glb_en,
   output logic [NHOST-1:0]      host_irq
);
   localparam int CHW = $clog2(NCHAN);
   localparam logic [7:0] NCHAN_B = 8'(NCHAN);

   for (genvar s = 0; s < NSRC; s++) begin : g_lookup
      logic [7:0] tgt;
      always_comb begin
         if (smap[s] < NCHAN_B) tgt = hmap[smap[s][CHW-1:0]];
         else                   tgt = 8'hFF;
      end
   end

   for (genvar h = 0; h < NHOST; h++) begin : g_host
      logic [NSRC-1:0] hit;
      for (genvar s = 0; s < NSRC; s++) begin : g_hit
         assign hit[s] = live[s] && (g_lookup[s].tgt == 8'(h));
      end
      assign host_irq[h] = glb_en & hen[h] & (|hit);
   end
endmodule

// File: rtl/mapintc_core.sv
module mapintc_core
   import mapintc_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int NCHAN = 8,
   parameter int NHOST = 2,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    bus_addr,
   input  logic [31:0]      wr_data,
   output logic [31:0]      rd_data,
   input  logic [NSRC-1:0]  src_in,
   output logic [NHOST-1:0] host_irq
);
   localparam int SIW  = $clog2(NSRC);
   localparam int HIW  = $clog2(NHOST);
   localparam int SMW  = NSRC / 4;
   localparam int HMW  = NCHAN / 4;

   if (NSRC < 4 || NSRC > 32 || (NSRC % 4) != 0)
      $error("NSRC must be a multiple of 4 in 4..32");
   if (NCHAN < 4 || NCHAN > 32 || (NCHAN % 4) != 0)
      $error("NCHAN must be a multiple of 4 in 4..32");
   if (NHOST < 2 || NHOST > 8)
      $error("NHOST must be in 2..8");
   if (AW < 6)
      $error("AW must reach the map words");

   logic                  glb_en;
   logic [NSRC-1:0]       en, typ, pol, stat, clr;
   logic [NHOST-1:0]      hen;
   logic [NSRC-1:0][7:0]  smap;
   logic [NCHAN-1:0][7:0] hmap;

   function automatic logic hit(input logic [AW-1:0] a, input int reg_addr);
      return wr_en && (a == AW'(reg_addr));
   endfunction

   assign clr = hit(bus_addr, A_STAT) ? wr_data[NSRC-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glb_en <= 1'b0;
         en     <= '0;
         typ    <= '0;
         pol    <= '1;
         hen    <= '0;
         smap   <= '0;
         hmap   <= '0;
      end else if (wr_en) begin
         if (bus_addr == AW'(A_GLB)) glb_en <= wr_data[0];
         if (bus_addr == AW'(A_ESET) && wr_data < 32'(NSRC))
            en[wr_data[SIW-1:0]] <= 1'b1;
         if (bus_addr == AW'(A_ECLR) && wr_data < 32'(NSRC))
            en[wr_data[SIW-1:0]] <= 1'b0;
         if (bus_addr == AW'(A_HEN)) hen <= wr_data[NHOST-1:0];
         if (bus_addr == AW'(A_HSET) && wr_data < 32'(NHOST))
            hen[wr_data[HIW-1:0]] <= 1'b1;
         if (bus_addr == AW'(A_HCLR) && wr_data < 32'(NHOST))
            hen[wr_data[HIW-1:0]] <= 1'b0;
         if (bus_addr == AW'(A_TYPE)) typ <= wr_data[NSRC-1:0];
         if (bus_addr == AW'(A_POL))  pol <= wr_data[NSRC-1:0];
         for (int w = 0; w < SMW; w++)
            if (bus_addr == AW'(A_SMAP + w))
               for (int k = 0; k < 4; k++) smap[w*4+k] <= wr_data[8*k +: 8];
         for (int w = 0; w < HMW; w++)
            if (bus_addr == AW'(A_HMAP + w))
               for (int k = 0; k < 4; k++) hmap[w*4+k] <= wr_data[8*k +: 8];
      end
   end

   always_comb begin
      rd_data = '0;
      if (bus_addr == AW'(A_REV))  rd_data = REV_ID;
      if (bus_addr == AW'(A_GLB))  rd_data[0] = glb_en;
      if (bus_addr == AW'(A_STAT)) rd_data[NSRC-1:0] = stat;
      if (bus_addr == AW'(A_EN))   rd_data[NSRC-1:0] = en;
      if (bus_addr == AW'(A_HEN))  rd_data[NHOST-1:0] = hen;
      if (bus_addr == AW'(A_TYPE)) rd_data[NSRC-1:0] = typ;
      if (bus_addr == AW'(A_POL))  rd_data[NSRC-1:0] = pol;
      for (int w = 0; w < SMW; w++)
         if (bus_addr == AW'(A_SMAP + w))
            for (int k = 0; k < 4; k++) rd_data[8*k +: 8] = smap[w*4+k];
      for (int w = 0; w < HMW; w++)
         if (bus_addr == AW'(A_HMAP + w))
            for (int k = 0; k < 4; k++) rd_data[8*k +: 8] = hmap[w*4+k];
   end

   mapintc_srccond #(.NSRC(NSRC)) u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_in (src_in),
      .typ    (typ),
      .pol    (pol),
      .clr    (clr),
      .stat   (stat)
   );

   mapintc_route #(.NSRC(NSRC), .NCHAN(NCHAN), .NHOST(NHOST)) u_route (
      .live     (stat & en),
      .smap     (smap),
      .hmap     (hmap),
      .hen      (hen),
      .glb_en   (glb_en),
      .host_irq (host_irq)
   );
endmodule

// File: rtl/mapintc_core_chk.sv
module mapintc_core_chk
   import mapintc_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int NHOST = 2,
   parameter int AW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [AW-1:0]    bus_addr,
   input logic [31:0]      wr_data,
   input logic [NSRC-1:0]  src_in,
   input logic [NHOST-1:0] host_irq,
   input logic             glb_en,
   input logic [NSRC-1:0]  stat,
   input logic [NSRC-1:0]  en,
   input logic [NSRC-1:0]  typ,
   input logic [NSRC-1:0]  pol,
   input logic [NHOST-1:0] hen
);
   logic stat_wr, idx_wr;
   assign stat_wr = wr_en && (bus_addr == AW'(A_STAT));
   assign idx_wr  = wr_en && (bus_addr == AW'(A_ESET) || bus_addr == AW'(A_ECLR));

   // R9
   glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |-> (host_irq == '0));

   // R6
   hen_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((host_irq & ~hen) == '0));

   // R4
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr |=> (($past(stat) & ~stat) == '0));

   // R4
   w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> ((($past(stat) & ~$past(wr_data[NSRC-1:0])) & ~stat) == '0));

   // R2
   level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (($past(~typ & ~(src_in ^ pol)) & ~stat) == '0));

   // R5
   en_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_wr |=> ($countones(en ^ $past(en)) <= 1));

   // R10
   no_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & en) == '0) |-> (host_irq == '0));
endmodule

bind mapintc_core mapintc_core_chk #(.NSRC(NSRC), .NHOST(NHOST), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .bus_addr (bus_addr),
   .wr_data  (wr_data),
   .src_in   (src_in),
   .host_irq (host_irq),
   .glb_en   (glb_en),
   .stat     (stat),
   .en       (en),
   .typ      (typ),
   .pol      (pol),
   .hen      (hen)
);

// File: tb/mapintc_core_bench.sv
module mapintc_core_bench;
   localparam int NS = 32;
   localparam int NC = 8;
   localparam int NH = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [31:0] src_in = '0;
   logic [1:0]  host_irq;

   int checks = 0;
   int errors = 0;

   // bench model
   logic [31:0] m_typ, m_pol, m_en, m_stat, m_prev;
   logic        m_glb;
   logic [1:0]  m_hen;
   logic [7:0]  m_smap [NS];
   logic [7:0]  m_hmap [NC];

   always #4 clk = ~clk;

   mapintc_core u_mapintc_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .bus_addr(bus_addr),
      .wr_data(wr_data), .rd_data(rd_data), .src_in(src_in), .host_irq(host_irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_typ = '0; m_pol = '1; m_en = '0; m_stat = '0; m_prev = '0;
      m_glb = 1'b0; m_hen = '0;
      for (int i = 0; i < NS; i++) m_smap[i] = '0;
      for (int i = 0; i < NC; i++) m_hmap[i] = '0;
   endtask

   task automatic model_edge(input logic w, input logic [7:0] a, input logic [31:0] d,
                             input logic [31:0] s);
      logic [31:0] clrm;
      clrm = (w && a == 8'h02) ? d : 32'h0;
      for (int i = 0; i < NS; i++) begin
         logic act, trig;
         act  = (s[i] == m_pol[i]);
         trig = m_typ[i] ? (act && (s[i] != m_prev[i])) : act;
         m_stat[i] = trig | (m_stat[i] & ~clrm[i]);
      end
      m_prev = s;
      if (w) begin
         case (a)
            8'h01: m_glb = d[0];
            8'h04: if (d < 32) m_en[d[4:0]] = 1'b1;
            8'h05: if (d < 32) m_en[d[4:0]] = 1'b0;
            8'h06: m_hen = d[1:0];
            8'h07: if (d < 2) m_hen[d[0]] = 1'b1;
            8'h08: if (d < 2) m_hen[d[0]] = 1'b0;
            8'h09: m_typ = d;
            8'h0A: m_pol = d;
            default: begin
               if (a >= 8'h10 && a < 8'h18)
                  for (int k = 0; k < 4; k++) m_smap[(a - 8'h10) * 4 + k] = d[8*k +: 8];
               if (a >= 8'h18 && a < 8'h1A)
                  for (int k = 0; k < 4; k++) m_hmap[(a - 8'h18) * 4 + k] = d[8*k +: 8];
            end
         endcase
      end
   endtask

   function automatic logic [1:0] exp_host();
      logic [1:0] r;
      r = '0;
      for (int h = 0; h < NH; h++)
         for (int i = 0; i < NS; i++)
            if (m_stat[i] && m_en[i] && m_smap[i] < NC && m_hmap[m_smap[i][2:0]] == 8'(h))
               r[h] = 1'b1;
      return r & m_hen & {2{m_glb}};
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      logic [31:0] r;
      r = '0;
      case (a)
         8'h00: r = 32'h0001_0203;
         8'h01: r = {31'b0, m_glb};
         8'h02: r = m_stat;
         8'h03: r = m_en;
         8'h06: r = {30'b0, m_hen};
         8'h09: r = m_typ;
         8'h0A: r = m_pol;
         default: begin
            if (a >= 8'h10 && a < 8'h18)
               for (int k = 0; k < 4; k++) r[8*k +: 8] = m_smap[(a - 8'h10) * 4 + k];
            if (a >= 8'h18 && a < 8'h1A)
               for (int k = 0; k < 4; k++) r[8*k +: 8] = m_hmap[(a - 8'h18) * 4 + k];
         end
      endcase
      return r;
   endfunction

   // one clock: drive at negedge, model at posedge, check outputs just after
   task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] s, input string tag);
      @(negedge clk);
      wr_en = w; bus_addr = a; wr_data = d; src_in = s;
      @(posedge clk);
      model_edge(w, a, d, s);
      #1;
      chk(tag, {30'b0, host_irq}, {30'b0, exp_host()});
   endtask

   // read between edges, within the high phase
   task automatic rd_chk(input logic [7:0] a, input string tag);
      wr_en = 1'b0; bus_addr = a;
      #1;
      chk(tag, rd_data, exp_read(a));
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] alist [11];
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      bus_addr = 8'h00; #1; chk("R1 revision", rd_data, 32'h0001_0203);
      chk("R1 host low after reset", {30'b0, host_irq}, 32'h0);
      bus_addr = 8'h02; #1; chk("R1 pending after reset", rd_data, 32'h0);
      bus_addr = 8'h0A; #1; chk("R1 polarity after reset", rd_data, 32'hFFFF_FFFF);

      step(1, 8'h01, 32'h1, 32'h0, "R9");
      step(1, 8'h06, 32'h3, 32'h0, "R6");
      rd_chk(8'h06, "R6 host mask");
      // R2 level source 3
      step(1, 8'h04, 32'd3, 32'h8, "R10 level source raises host 0");
      rd_chk(8'h02, "R2 level set");
      step(1, 8'h02, 32'h8, 32'h8, "R2");
      rd_chk(8'h02, "R2 set wins over clear");
      step(1, 8'h02, 32'h0, 32'h0, "R4");
      rd_chk(8'h02, "R4 zero write keeps");
      step(1, 8'h02, 32'h8, 32'h0, "R4");
      rd_chk(8'h02, "R4 one write clears");
      // R3 edge source 5, falling
      step(1, 8'h0A, 32'hFFFF_FFDF, 32'h0, "R3");
      step(1, 8'h09, 32'h0000_0020, 32'h20, "R3");
      step(1, 8'h02, 32'h20, 32'h20, "R3");
      rd_chk(8'h02, "R3 cleared, no edge");
      step(0, 8'h00, 32'h0, 32'h20, "R3");
      rd_chk(8'h02, "R3 rising ignored for falling polarity");
      step(0, 8'h00, 32'h0, 32'h0, "R3");
      rd_chk(8'h02, "R3 falling edge sets");
      step(0, 8'h00, 32'h0, 32'h0, "R3");
      rd_chk(8'h02, "R3 stays set");
      rd_chk(8'h09, "R12 type");
      // R5 enables
      step(1, 8'h04, 32'd5, 32'h0, "R10 edge source raises host 0");
      rd_chk(8'h03, "R5 enable set");
      step(1, 8'h04, 32'd40, 32'h0, "R5");
      rd_chk(8'h03, "R5 out-of-range ignored");
      // R11
      step(1, 8'h05, 32'd5, 32'h0, "R11 disable masks output");
      rd_chk(8'h02, "R11 pending kept");
      step(1, 8'h04, 32'd5, 32'h0, "R11 re-enable reasserts");
      // R9
      step(1, 8'h01, 32'h0, 32'h0, "R9 global off");
      step(1, 8'h01, 32'h1, 32'h0, "R9 global on");
      // R6
      step(1, 8'h08, 32'd0, 32'h0, "R6 host clear");
      step(1, 8'h08, 32'd7, 32'h0, "R6 out-of-range ignored");
      step(1, 8'h07, 32'd0, 32'h0, "R6 host set");
      // R7 / R8
      step(1, 8'h11, 32'h0000_0600, 32'h0, "R7 source 5 to channel 6");
      step(1, 8'h19, 32'h0001_0000, 32'h0, "R8 channel 6 to host 1");
      rd_chk(8'h11, "R7 map readback");
      rd_chk(8'h19, "R8 map readback");
      step(1, 8'h19, 32'h0003_0000, 32'h0, "R8 host out of range");
      step(1, 8'h19, 32'h0001_0000, 32'h0, "R8");
      step(1, 8'h11, 32'h0000_0900, 32'h0, "R7 channel out of range");
      rd_chk(8'h07, "R12 index register reads 0");
      rd_chk(8'h0F, "R12 hole reads 0");

      // random phase
      alist = '{8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h0A, 8'h10, 8'h18};
      for (int n = 0; n < 3000; n++) begin
         logic [7:0]  a;
         logic [31:0] d, s;
         logic        w;
         w = ($urandom % 3) == 0;
         a = alist[$urandom % 11];
         if (a == 8'h10) a = 8'h10 + 8'($urandom % 8);
         if (a == 8'h18) a = 8'h18 + 8'($urandom % 2);
         case (a)
            8'h04, 8'h05: d = $urandom % 40;
            8'h07, 8'h08: d = $urandom % 3;
            8'h01:        d = ($urandom % 5 == 0) ? 32'h0 : 32'h1;
            default:
               if (a >= 8'h10)
                  d = {8'($urandom % 10), 8'($urandom % 10), 8'($urandom % 10), 8'($urandom % 10)};
               else
                  d = $urandom;
         endcase
         if (a >= 8'h18 && a < 8'h1A)
            d = {8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3), 8'($urandom % 3)};
         s = src_in ^ ($urandom & $urandom & $urandom);
         step(w, a, d, s, "R10 random host output");
         rd_chk(alist[$urandom % 11], "R12 random readback");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule